// File: doc/BRIEF.md
# Double-Precision Round and Pack Unit

This unit is the final step of a floating-point datapath. It receives a result that is already normalised: a sign, a signed unbiased exponent and a 56-bit mantissa. The mantissa carries the leading one at bit 55, then 52 fraction bits, then guard, round and sticky bits in bits 2..0. The unit rounds this value under one of four rounding modes and packs it into a 64-bit IEEE 754 binary64 word. It also reports inexact, underflow and overflow flags.

Values below the smallest normal exponent are shifted down into the subnormal range. Every bit that falls off the bottom is folded into the sticky bit. An optional flush control replaces any such value with zero or with the smallest subnormal, depending on the mode and the sign. Values beyond the largest normal exponent become infinity or the largest finite magnitude, again depending on the mode and the sign.

The unit has two register stages, round and then pack, with a valid bit that travels alongside the data. Callers must present a nonzero mantissa with bit 55 set. Producing an exact zero, handling NaN and normalising the input are left to upstream logic.

Top module: `fp_round_pack`

## Requirements
- R1: When the input mantissa bits 2..0 are zero and the exponent lies in [-1022, +1023], the output is {sign, exponent+1023, mantissa bits 54..3} and no flag is raised.
- R2: Mode 0 (nearest-even) adds 3 plus mantissa bit 3 whenever bits 2..0 are nonzero. A guard-only tie therefore rounds toward an even fraction, and inexact is raised.
- R3: Mode 1 (toward zero) never increments. Mode 2 (toward +inf) adds 8 only for a positive sign. Mode 3 (toward -inf) adds 8 only for a negative sign. Any nonzero bits 2..0 raise inexact.
- R4: If rounding carries out above bit 55, the mantissa shifts right by one and the exponent increases by one. An all-ones fraction that rounds up yields a zero fraction with the next exponent.
- R5: With flush_den=1 and an exponent below -1022, the result is a zero of the input sign for modes 0 and 1. Mode 2 gives +smallest subnormal (0x0000000000000001) for a positive sign and -0 for a negative sign. Mode 3 gives -smallest subnormal for a negative sign and +0 for a positive sign. Underflow and inexact are both raised.
- R6: At exponent -1023, if rounding at full precision carries past bit 55, the result is the smallest normal (exponent field 1, fraction 0). Inexact is raised and underflow is not.
- R7: For other exponents below -1022 (flush_den=0), the mantissa is shifted right by (-1022 - exponent), with the lost bits ORed into bit 0, and then rounded. The result is packed with exponent field 0, or with field 1 when rounding reaches bit 55.
- R8: Underflow is raised exactly when the value is inexact and bit 55 is clear before rounding, that is, when the value was denormalised.
- R9: An exponent above +1023 after rounding raises overflow and inexact. Mode 0 gives infinity. Mode 1 gives the largest finite value (0x7FEFFFFFFFFFFFFF with the sign). Mode 2 gives +inf or -max. Mode 3 gives +max or -inf.
- R10: The result and all three flags appear two clock edges after the input is accepted. out_valid follows in_valid with the same two-cycle delay, and back-to-back inputs are accepted every cycle.
- R11: While rst_n is low, out_valid is 0 and out_result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value is present |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | 13 | Signed unbiased exponent (two's complement) |
| in_mant | input | 56 | Leading one at bit 55, fraction bits 54..3, guard/round/sticky bits 2..0 |
| in_mode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| flush_den | input | 1 | Flush values below the normal range |
| out_valid | output | 1 | Result is present |
| out_result | output | 64 | Packed binary64 value |
| out_inexact | output | 1 | Result differs from the exact value |
| out_underflow | output | 1 | Tiny and inexact, or flushed |
| out_overflow | output | 1 | Exponent exceeded the normal range |

## Verification
The bench sweeps exponents on both sides of -1022, -1023 and +1023, and far into the subnormal range. It crosses them with mantissas built as exact values, ties, sticky-only tails and all-ones carries, under every mode, both signs and both flush settings, and compares each result against an exact integer rounding model. An off-by-one in the subnormal shift would lose or double the last fraction bit. A sticky bit that is dropped would round a near-tie toward zero. The exponent -1023 carry case catches a design that flags underflow on a value that became the smallest normal. The overflow and flush tables catch a swapped sign or mode choice, which would show up as infinity where the largest finite value is due, or as -0 where the smallest subnormal is due.

// File: rtl/fp_round_pack.sv
module fp_round_pack #(
  parameter int FRAC_W = 52,
  parameter int EXP_W  = 11,
  parameter int EIN_W  = 13
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_sign,
  input  logic signed [EIN_W-1:0]       in_exp,
  input  logic [FRAC_W+3:0]             in_mant,
  input  logic [1:0]                    in_mode,
  input  logic                          flush_den,
  output logic                          out_valid,
  output logic [EXP_W+FRAC_W:0]         out_result,
  output logic                          out_inexact,
  output logic                          out_underflow,
  output logic                          out_overflow
);
  localparam int MW   = FRAC_W + 4;
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int EMIN = 1 - BIAS;
  localparam int EMAX = BIAS;
  localparam int SW   = $clog2(MW + 1);

  function automatic logic [MW:0] rnd(input logic s, input logic [1:0] md, input logic [MW-1:0] m);
    logic [MW:0] inc;
    inc = '0;
    if (m[2:0] != 3'b000) begin
      case (md)
        2'd0:    inc = (MW+1)'(3) + (MW+1)'(m[3]);
        2'd2:    inc = s ? '0 : (MW+1)'(8);
        2'd3:    inc = s ? (MW+1)'(8) : '0;
        default: inc = '0;
      endcase
    end
    return {1'b0, m} + inc;
  endfunction

  int              ein, es, e1, e2;
  logic            tiny, pre_inx;
  logic [SW-1:0]   sh;
  logic [MW-1:0]   lost, m1;
  logic [MW:0]     r0, r1;
  logic [FRAC_W:0] mfin;

  always_comb begin
    ein     = int'(in_exp);
    tiny    = ein < EMIN;
    es      = EMIN - ein;
    sh      = (es > MW) ? SW'(MW) : SW'(es);
    r0      = rnd(in_sign, in_mode, in_mant);
    lost    = ~({MW{1'b1}} << sh);
    m1      = in_mant;
    e1      = ein;
    pre_inx = 1'b0;
    if (tiny) begin
      e1 = EMIN;
      if (ein == EMIN - 1 && r0[MW]) begin
        m1      = r0[MW:1] & ~MW'(7);
        pre_inx = 1'b1;
      end else begin
        m1 = (in_mant >> sh) | MW'(|(in_mant & lost));
      end
    end
    r1 = rnd(in_sign, in_mode, m1);
    if (r1[MW]) begin
      mfin = r1[MW:4];
      e2   = e1 + 1;
    end else begin
      mfin = r1[MW-1:3];
      e2   = e1;
    end
  end

  logic                  s1_valid, s1_sign, s1_flush, s1_inx, s1_unf;
  logic [1:0]            s1_mode;
  logic signed [EIN_W:0] s1_exp;
  logic [FRAC_W:0]       s1_mant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_sign  <= 1'b0;
      s1_flush <= 1'b0;
      s1_inx   <= 1'b0;
      s1_unf   <= 1'b0;
      s1_mode  <= '0;
      s1_exp   <= '0;
      s1_mant  <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_sign  <= in_sign;
      s1_flush <= tiny && flush_den;
      s1_inx   <= pre_inx || (m1[2:0] != 3'b000);
      s1_unf   <= (m1[2:0] != 3'b000) && !m1[MW-1];
      s1_mode  <= in_mode;
      s1_exp   <= (EIN_W+1)'(e2);
      s1_mant  <= mfin;
    end
  end

  wire [W-1:0] inf_v  = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
  wire [W-1:0] max_v  = {s1_sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
  wire [W-1:0] zero_v = {s1_sign, {(W-1){1'b0}}};
  wire [W-1:0] tmin_v = {s1_sign, {EXP_W{1'b0}}, FRAC_W'(1)};
  wire         ovf    = !s1_flush && (int'(s1_exp) > EMAX);
  wire [EXP_W-1:0] fld = s1_mant[FRAC_W] ? EXP_W'(int'(s1_exp) + BIAS) : '0;

  logic [W-1:0] res;
  always_comb begin
    res = {s1_sign, fld, s1_mant[FRAC_W-1:0]};
    if (s1_flush) begin
      case (s1_mode)
        2'd2:    res = s1_sign ? zero_v : tmin_v;
        2'd3:    res = s1_sign ? tmin_v : zero_v;
        default: res = zero_v;
      endcase
    end else if (ovf) begin
      case (s1_mode)
        2'd0:    res = inf_v;
        2'd1:    res = max_v;
        2'd2:    res = s1_sign ? max_v : inf_v;
        default: res = s1_sign ? inf_v : max_v;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_result    <= '0;
      out_inexact   <= 1'b0;
      out_underflow <= 1'b0;
      out_overflow  <= 1'b0;
    end else begin
      out_valid     <= s1_valid;
      out_result    <= res;
      out_inexact   <= s1_flush || ovf || s1_inx;
      out_underflow <= s1_flush || (s1_unf && !ovf);
      out_overflow  <= ovf;
    end
  end
endmodule

module fp_round_pack_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         out_valid,
  input logic [W-1:0] out_result,
  input logic         out_inexact,
  input logic         out_underflow,
  input logic         out_overflow
);
  assert_ovf_inexact_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_inexact);
  assert_ovf_exp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> &out_result[W-2:W-11]);
  assert_unf_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_inexact);
  assert_exact_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_inexact |-> !out_underflow && !out_overflow);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> ##2 !out_valid);
endmodule

bind fp_round_pack fp_round_pack_chk #(.W(EXP_W + FRAC_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_result(out_result), .out_inexact(out_inexact),
  .out_underflow(out_underflow), .out_overflow(out_overflow));

// File: tb/fp_round_pack_tb.sv
module fp_round_pack_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sign = 1'b0, flush_den = 1'b0;
  logic signed [12:0] in_exp = '0;
  logic [55:0] in_mant = '0;
  logic [1:0]  in_mode = '0;
  logic        out_valid, out_inexact, out_underflow, out_overflow;
  logic [63:0] out_result;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_round_pack u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_mode(in_mode), .flush_den(flush_den),
    .out_valid(out_valid), .out_result(out_result), .out_inexact(out_inexact),
    .out_underflow(out_underflow), .out_overflow(out_overflow));

  localparam logic [62:0] INF_M = 63'h7FF0000000000000;
  localparam logic [62:0] MAX_M = 63'h7FEFFFFFFFFFFFFF;

  function automatic void round_q(input logic [55:0] m, input int drop, input logic s,
                                  input logic [1:0] md, output logic [63:0] q, output logic nz);
    logic [127:0] ext, qq, rem, half;
    logic up;
    ext  = {72'b0, m};
    qq   = ext >> drop;
    rem  = ext - (qq << drop);
    half = 128'b1 << (drop - 1);
    nz   = rem != 0;
    case (md)
      2'd0:    up = (rem > half) || (rem == half && qq[0]);
      2'd1:    up = 1'b0;
      2'd2:    up = nz && !s;
      default: up = nz && s;
    endcase
    q = qq[63:0] + 64'(up);
  endfunction

  function automatic void ref_model(input logic s, input int e, input logic [55:0] m,
      input logic [1:0] md, input logic fd, output logic [63:0] res,
      output logic inx, output logic unf, output logic ovf, output string tag);
    logic [63:0] q, q3;
    logic nz, nz3, special;
    int drop, ee;
    inx = 0; unf = 0; ovf = 0;
    round_q(m, 3, s, md, q3, nz3);
    special = (e == -1023) && q3[53];
    if (e < -1022) begin
      drop = 3 + (-1022 - e);
      if (drop > 120) drop = 120;
      if (fd) begin
        inx = 1; unf = 1; tag = "R5";
        case (md)
          2'd2:    res = s ? {1'b1, 63'b0} : 64'd1;
          2'd3:    res = s ? {1'b1, 63'd1} : 64'd0;
          default: res = {s, 63'b0};
        endcase
      end else begin
        round_q(m, drop, s, md, q, nz);
        res = {s, q[62:0]};
        inx = nz;
        unf = nz && !special;
        tag = special ? "R6" : "R7 R8";
      end
    end else begin
      q = q3; ee = e;
      if (q[53]) begin q = q >> 1; ee++; end
      if (ee > 1023) begin
        ovf = 1; inx = 1; tag = "R9";
        case (md)
          2'd0:    res = {s, INF_M};
          2'd1:    res = {s, MAX_M};
          2'd2:    res = s ? {s, MAX_M} : {s, INF_M};
          default: res = s ? {s, INF_M} : {s, MAX_M};
        endcase
      end else begin
        res = {s, 11'(ee + 1023), q[51:0]};
        inx = nz3;
        if (!nz3) tag = "R1";
        else if (q3[53]) tag = "R4";
        else if (md == 0) tag = "R2";
        else tag = "R3";
      end
    end
  endfunction

  task automatic drive(input logic s, input int e, input logic [55:0] m, input logic [1:0] md, input logic fd);
    in_valid = 1; in_sign = s; in_exp = 13'(e); in_mant = m; in_mode = md; flush_den = fd;
  endtask

  task automatic check_out(input logic s, input int e, input logic [55:0] m, input logic [1:0] md, input logic fd);
    logic [63:0] xr; logic xi, xu, xo; string tg;
    ref_model(s, e, m, md, fd, xr, xi, xu, xo, tg);
    tests++;
    if (!out_valid || out_result !== xr || out_inexact !== xi || out_underflow !== xu || out_overflow !== xo) begin
      fails++;
      $display("FAIL %s e=%0d m=%h md=%0d fd=%0d s=%0d: got v=%0b %h i%0b u%0b o%0b exp %h i%0b u%0b o%0b",
               tg, e, m, md, fd, s, out_valid, out_result, out_inexact, out_underflow, out_overflow,
               xr, xi, xu, xo);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  int exps[19] = '{-1200, -1100, -1078, -1077, -1076, -1075, -1074, -1073, -1030, -1024,
                   -1023, -1022, -1021, 0, 1, 1022, 1023, 1024, 1030};
  logic [55:0] mants[10] = '{56'h80000000000000, 56'hFFFFFFFFFFFFFF, 56'h80000000000004,
                             56'h8000000000000C, 56'h80000000000001, 56'h80000000000005,
                             56'hA5A5A5A5A5A5A3, 56'hFFFFFFFFFFFFFC, 56'hC0000000000008,
                             56'hFFFFFFFFFFFFF8};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if (out_valid !== 0 || out_result !== 0 || out_inexact || out_underflow || out_overflow) begin
      fails++;
      $display("FAIL R11 reset: got v=%0b r=%h exp v=0 r=0", out_valid, out_result);
    end
    rst_n = 1;
    @(negedge clk);
    for (int ei = 0; ei < 19; ei++)
      for (int mi = 0; mi < 10; mi++)
        for (int md = 0; md < 4; md++)
          for (int k = 0; k < 4; k++) begin
            drive(k[0], exps[ei], mants[mi], 2'(md), k[1]);
            @(negedge clk);
            in_valid = 0;
            if (out_valid !== 0) begin
              tests++; fails++;
              $display("FAIL R10 early valid: got 1 exp 0");
            end
            @(negedge clk);
            check_out(k[0], exps[ei], mants[mi], 2'(md), k[1]);
          end
    // R10: back-to-back burst of three
    for (int i = 0; i < 5; i++) begin
      if (i >= 2) check_out(1'b1, exps[i + 7], mants[i + 1], 2'(i - 2), 1'b0);
      if (i < 3) drive(1'b1, exps[i + 9], mants[i + 3], 2'(i), 1'b0);
      else in_valid = 0;
      @(negedge clk);
    end
    tests++;
    if (out_valid !== 0) begin
      fails++;
      $display("FAIL R10 valid after burst: got 1 exp 0");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule